// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block runs single read and write transfers on an external bus whose sixteen low lines carry first an address and then data. Four more lines carry the top address bits and, later in the cycle, a status nibble. On the internal side, a requester presents a transfer: direction, memory or I/O space, a 16-bit segment, a 16-bit offset, write data and a word/byte size flag. The controller forms the 20-bit physical address as the segment shifted left by four plus the offset. It then walks the bus through an address phase, a strobe phase, a ready-sampled phase with optional wait states, and a closing phase.

External parts latch the address on the address-latch pulse and steer the shared lines through a transceiver. The controller drives the transceiver's enable and direction, and it drives the read and write strobes, the space select and an active-low upper-lane enable. A slow device holds the ready input low to stretch the cycle. When the transfer ends, the requester sees a one-cycle completion pulse, with the read data already aligned to the low byte for byte reads.

Top module: `mxbus_ctrl`

## Requirements
- R1: The physical address is (segment << 4) + offset, truncated to 20 bits. In the address phase (T1), adOut carries address bits 15..0 and upOut carries bits 19..16.
- R2: aleOut is high in exactly one cycle per transfer: the T1 cycle that directly follows the idle cycle in which the request was accepted.
- R3: After T1 and up to the end of the transfer, upOut carries the status nibble {0, 1, write, io}.
- R4: With ready high when first sampled, a transfer occupies exactly four cycles (T1, T2, T3, T4). The active strobe (rdN for reads, wrN for writes) is low in T2 and T3 and high in T1 and T4.
- R5: readyIn is sampled only at the end of T3 and of each wait cycle. Each low sample adds one wait cycle with the strobe held low. The level of readyIn during T2 has no effect.
- R6: Read data is taken from adIn when ready is sampled high. A word read returns adIn unchanged. A byte read at an even address returns adIn[7:0], and a byte read at an odd address returns adIn[15:8], both zero-extended to 16 bits.
- R7: During a write, adOe is high from T1 through T4. After T1, adOut carries the write data: a word unchanged, and a byte (taken from wdata[7:0]) copied onto both lanes. During a read, adOe is high only in T1, and adOut is 0 after T1.
- R8: dtR is high for all cycles of a write and low for a read. mIo equals the I/O flag for all cycles of a transfer. Both are low when the controller is idle.
- R9: denN is low exactly while the read or write strobe is low, and high otherwise.
- R10: bheN is low from T1 through T4 for word transfers and for byte transfers at an odd address. It is high for byte transfers at an even address and whenever the controller is idle.
- R11: reqAck is high for one cycle, in T1. doneValid is high for one cycle, in the cycle after T4, and rdData holds the read result from that cycle on.
- R12: While rst is high, the controller is idle: aleOut=0, rdN=wrN=denN=bheN=1, adOe=0, dtR=0. A transfer that reset interrupts produces no doneValid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Transfer request, held until reqAck |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIo | input | 1 | 1 = I/O space, 0 = memory space |
| reqWord | input | 1 | 1 = 16-bit transfer, 0 = byte transfer |
| reqSeg | input | 16 | Segment value |
| reqOff | input | 16 | Offset value |
| reqWdata | input | 16 | Write data (byte in bits 7..0) |
| reqAck | output | 1 | Request accepted (T1) |
| doneValid | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Aligned read result |
| adOut | output | 16 | Shared address/data lines, driven value |
| adOe | output | 1 | Drive enable for the shared lines |
| adIn | input | 16 | Shared address/data lines, received value |
| upOut | output | 4 | Upper address bits / status nibble |
| aleOut | output | 1 | Address latch pulse |
| bheN | output | 1 | Upper byte lane enable, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| denN | output | 1 | Transceiver enable, active low |
| dtR | output | 1 | Transceiver direction, 1 = outbound |
| mIo | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| readyIn | input | 1 | Device ready; low inserts waits |

## Verification
The hardest situation to reach from the ports is a reset that lands in the middle of a wait state, because ready must be held low long enough to keep the cycle open. The bench starts a read, keeps readyIn low through T3 and into wait cycles, then raises rst and checks that the strobes fall back to idle and that no completion pulse ever appears. The sweep also holds readyIn low during T2 on every transfer with waits, so a controller that samples ready too early would lose a wait cycle and show up in the cycle count.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;       // latch the request
    logic capture;    // latch read data
    logic ale;        // address latch pulse
    logic addrPhase;  // T1
    logic dataPhase;  // T2..T4
    logic strobe;     // T2, T3, waits
    logic busy;       // any non-idle phase
  } busCtl_t;
endpackage

// File: rtl/mxbus_seq.sv
module mxbus_seq
  import mxbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    readyIn,
  output busCtl_t ctl,
  output logic    reqAck,
  output logic    doneValid
);
  phase_e phase, phaseNxt;

  always_comb begin
    phaseNxt = phase;
    unique case (phase)
      PH_IDLE: if (reqValid) phaseNxt = PH_T1;
      PH_T1:   phaseNxt = PH_T2;
      PH_T2:   phaseNxt = PH_T3;
      PH_T3,
      PH_TW:   phaseNxt = readyIn ? PH_T4 : PH_TW;
      PH_T4:   phaseNxt = PH_IDLE;
      default: phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      doneValid <= 1'b0;
    end else begin
      phase     <= phaseNxt;
      doneValid <= (phase == PH_T4);
    end
  end

  always_comb begin
    ctl.load      = (phase == PH_IDLE) && reqValid;
    ctl.capture   = ((phase == PH_T3) || (phase == PH_TW)) && readyIn;
    ctl.ale       = (phase == PH_T1);
    ctl.addrPhase = (phase == PH_T1);
    ctl.dataPhase = (phase == PH_T2) || (phase == PH_T3) ||
                    (phase == PH_TW) || (phase == PH_T4);
    ctl.strobe    = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);
    ctl.busy      = (phase != PH_IDLE);
  end

  assign reqAck = (phase == PH_T1);
endmodule

// File: rtl/mxbus_dp.sv
module mxbus_dp
  import mxbus_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  busCtl_t              ctl,
  input  logic                 reqWrite,
  input  logic                 reqIo,
  input  logic                 reqWord,
  input  logic [OFF_W-1:0]     reqSeg,
  input  logic [OFF_W-1:0]     reqOff,
  input  logic [OFF_W-1:0]     reqWdata,
  input  logic [OFF_W-1:0]     adIn,
  output logic [OFF_W-1:0]     adOut,
  output logic                 adOe,
  output logic [SEG_SHIFT-1:0] upOut,
  output logic                 aleOut,
  output logic                 bheN,
  output logic                 rdN,
  output logic                 wrN,
  output logic                 denN,
  output logic                 dtR,
  output logic                 mIo,
  output logic [OFF_W-1:0]     rdData
);
  localparam int ADDR_W = OFF_W + SEG_SHIFT;
  localparam int BYTE_W = OFF_W / 2;

  logic [ADDR_W-1:0] physAddr;
  logic              isWr, isIo, isWord;
  logic [OFF_W-1:0]  wData;
  logic [OFF_W-1:0]  rdLane;
  logic [OFF_W-1:0]  wrLanes;
  logic [SEG_SHIFT-1:0] statusNib;
  logic              hiLane;

  always_ff @(posedge clk) begin
    if (rst) begin
      physAddr <= '0;
      isWr     <= 1'b0;
      isIo     <= 1'b0;
      isWord   <= 1'b0;
      wData    <= '0;
      rdData   <= '0;
    end else begin
      if (ctl.load) begin
        physAddr <= (ADDR_W'(reqSeg) << SEG_SHIFT) + ADDR_W'(reqOff);
        isWr     <= reqWrite;
        isIo     <= reqIo;
        isWord   <= reqWord;
        wData    <= reqWdata;
      end
      if (ctl.capture && !isWr) rdData <= rdLane;
    end
  end

  always_comb begin
    if (isWord)           rdLane = adIn;
    else if (physAddr[0]) rdLane = {{(OFF_W-BYTE_W){1'b0}}, adIn[OFF_W-1:BYTE_W]};
    else                  rdLane = {{(OFF_W-BYTE_W){1'b0}}, adIn[BYTE_W-1:0]};
  end

  assign wrLanes   = isWord ? wData : {wData[BYTE_W-1:0], wData[BYTE_W-1:0]};
  assign statusNib = SEG_SHIFT'({2'b01, isWr, isIo});
  assign hiLane    = isWord | physAddr[0];

  always_comb begin
    if (ctl.addrPhase)                adOut = physAddr[OFF_W-1:0];
    else if (ctl.dataPhase && isWr)   adOut = wrLanes;
    else                              adOut = '0;
    if (ctl.addrPhase)                upOut = physAddr[ADDR_W-1:OFF_W];
    else if (ctl.dataPhase)           upOut = statusNib;
    else                              upOut = '0;
  end

  assign aleOut = ctl.ale;
  assign adOe   = ctl.addrPhase | (ctl.dataPhase & isWr);
  assign rdN    = !(ctl.strobe & !isWr);
  assign wrN    = !(ctl.strobe & isWr);
  assign denN   = !ctl.strobe;
  assign dtR    = ctl.busy & isWr;
  assign mIo    = ctl.busy & isIo;
  assign bheN   = !(ctl.busy & hiLane);
endmodule

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl
  import mxbus_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 reqIo,
  input  logic                 reqWord,
  input  logic [OFF_W-1:0]     reqSeg,
  input  logic [OFF_W-1:0]     reqOff,
  input  logic [OFF_W-1:0]     reqWdata,
  output logic                 reqAck,
  output logic                 doneValid,
  output logic [OFF_W-1:0]     rdData,
  output logic [OFF_W-1:0]     adOut,
  output logic                 adOe,
  input  logic [OFF_W-1:0]     adIn,
  output logic [SEG_SHIFT-1:0] upOut,
  output logic                 aleOut,
  output logic                 bheN,
  output logic                 rdN,
  output logic                 wrN,
  output logic                 denN,
  output logic                 dtR,
  output logic                 mIo,
  input  logic                 readyIn
);
  busCtl_t ctl;

  mxbus_seq u_seq (
    .clk(clk), .rst(rst), .reqValid(reqValid), .readyIn(readyIn),
    .ctl(ctl), .reqAck(reqAck), .doneValid(doneValid)
  );

  mxbus_dp #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .reqWrite(reqWrite), .reqIo(reqIo), .reqWord(reqWord),
    .reqSeg(reqSeg), .reqOff(reqOff), .reqWdata(reqWdata),
    .adIn(adIn), .adOut(adOut), .adOe(adOe), .upOut(upOut),
    .aleOut(aleOut), .bheN(bheN), .rdN(rdN), .wrN(wrN),
    .denN(denN), .dtR(dtR), .mIo(mIo), .rdData(rdData)
  );
endmodule

// File: rtl/mxbus_chk.sv
module mxbus_chk #(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             reqAck,
  input logic             doneValid,
  input logic             adOe,
  input logic             aleOut,
  input logic             rdN,
  input logic             wrN,
  input logic             denN,
  input logic             dtR,
  input logic             readyIn
);
  // R2: latch pulse lasts one cycle and comes with the address driven
  a_r2_ale_pulse: assert property (@(posedge clk) disable iff (rst)
    aleOut |=> !aleOut);
  a_r2_ale_addr: assert property (@(posedge clk) disable iff (rst)
    aleOut |-> (adOe && rdN && wrN));

  // R5: a low ready keeps the strobe asserted into the next cycle
  a_r5_wait_hold: assert property (@(posedge clk) disable iff (rst)
    ((!rdN || !wrN) && !readyIn) |=> (!rdN || !wrN));

  // R4: read and write strobes never overlap
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!rdN && !wrN));

  // R8: direction follows the active strobe
  a_r8_dir_write: assert property (@(posedge clk) disable iff (rst)
    !wrN |-> (dtR && adOe));
  a_r8_dir_read: assert property (@(posedge clk) disable iff (rst)
    !rdN |-> (!dtR && !adOe));

  // R9: transceiver enabled only with a strobe
  a_r9_den: assert property (@(posedge clk) disable iff (rst)
    !denN |-> (!rdN || !wrN));

  // R11: single-cycle handshakes
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    doneValid |=> !doneValid);
  a_r11_ack_t1: assert property (@(posedge clk) disable iff (rst)
    reqAck |-> aleOut);

  // R12: reset forces idle
  a_r12_reset_idle: assert property (@(posedge clk)
    rst |=> (!aleOut && rdN && wrN && denN && !doneValid && !adOe));
endmodule

bind mxbus_ctrl mxbus_chk #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (
  .clk(clk), .rst(rst), .reqAck(reqAck), .doneValid(doneValid),
  .adOe(adOe), .aleOut(aleOut), .rdN(rdN), .wrN(wrN), .denN(denN),
  .dtR(dtR), .readyIn(readyIn)
);

// File: tb/sim_mxbus_ctrl.sv
module sim_mxbus_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqIo = 1'b0, reqWord = 1'b0;
  logic [15:0] reqSeg = '0, reqOff = '0, reqWdata = '0, adIn = '0;
  logic        readyIn = 1'b1;
  logic        reqAck, doneValid, adOe, aleOut, bheN, rdN, wrN, denN, dtR, mIo;
  logic [15:0] rdData, adOut;
  logic [3:0]  upOut;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mxbus_ctrl u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqIo(reqIo), .reqWord(reqWord), .reqSeg(reqSeg), .reqOff(reqOff),
    .reqWdata(reqWdata), .reqAck(reqAck), .doneValid(doneValid),
    .rdData(rdData), .adOut(adOut), .adOe(adOe), .adIn(adIn),
    .upOut(upOut), .aleOut(aleOut), .bheN(bheN), .rdN(rdN), .wrN(wrN),
    .denN(denN), .dtR(dtR), .mIo(mIo), .readyIn(readyIn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkIdle(input string tag);
    chk({tag, " ale"}, 32'(aleOut), 0);
    chk({tag, " rdN"}, 32'(rdN), 1);
    chk({tag, " wrN"}, 32'(wrN), 1);
    chk({tag, " denN"}, 32'(denN), 1);
    chk({tag, " bheN"}, 32'(bheN), 1);
    chk({tag, " adOe"}, 32'(adOe), 0);
    chk({tag, " dtR"}, 32'(dtR), 0);
    chk({tag, " mIo"}, 32'(mIo), 0);
  endtask

  task automatic xfer(input logic [15:0] seg, input logic [15:0] off,
                      input logic [15:0] wdat, input logic [15:0] rdv,
                      input bit wr, input bit io, input bit word, input int waits);
    logic [19:0] pa;
    logic [15:0] expRd, expWr;
    logic [3:0]  stat;
    logic        expBhe;
    pa     = ({4'h0, seg} << 4) + {4'h0, off};
    expRd  = word ? rdv : (off[0] ? {8'h00, rdv[15:8]} : {8'h00, rdv[7:0]});
    expWr  = word ? wdat : {wdat[7:0], wdat[7:0]};
    stat   = {2'b01, wr, io};
    expBhe = !(word || off[0]);

    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqIo = io; reqWord = word;
    reqSeg = seg; reqOff = off; reqWdata = wdat;
    readyIn = (waits == 0) ? 1'b1 : 1'b0;  // low during T2 tests R5
    adIn = 16'h0000;
    @(negedge clk);  // T1
    chk("R2 ale in T1", 32'(aleOut), 1);
    chk("R11 reqAck in T1", 32'(reqAck), 1);
    chk("R1 low address", 32'(adOut), 32'(pa[15:0]));
    chk("R1 upper address", 32'(upOut), 32'(pa[19:16]));
    chk("R7 adOe T1", 32'(adOe), 1);
    chk("R10 bheN T1", 32'(bheN), 32'(expBhe));
    chk("R8 dtR", 32'(dtR), 32'(wr));
    chk("R8 mIo", 32'(mIo), 32'(io));
    chk("R4 no strobe T1", 32'({rdN, wrN}), 32'h3);
    reqValid = 1'b0;
    adIn = rdv;
    @(negedge clk);  // T2
    chk("R2 ale drops T2", 32'(aleOut), 0);
    chk("R11 reqAck drops", 32'(reqAck), 0);
    chk("R3 status T2", 32'(upOut), 32'(stat));
    chk("R4 strobe T2", 32'({rdN, wrN}), wr ? 32'h2 : 32'h1);
    chk("R9 denN T2", 32'(denN), 0);
    chk("R7 data lanes T2", 32'(adOut), wr ? 32'(expWr) : 32'h0);
    chk("R7 adOe T2", 32'(adOe), 32'(wr));
    @(negedge clk);  // T3
    chk("R4 strobe T3", 32'({rdN, wrN}), wr ? 32'h2 : 32'h1);
    chk("R10 bheN T3", 32'(bheN), 32'(expBhe));
    readyIn = (waits == 0) ? 1'b1 : 1'b0;
    for (int k = 1; k <= waits; k++) begin
      @(negedge clk);  // wait cycle
      chk("R5 strobe held in wait", 32'({rdN, wrN}), wr ? 32'h2 : 32'h1);
      chk("R9 denN in wait", 32'(denN), 0);
      chk("R5 no early done", 32'(doneValid), 0);
      chk("R3 status in wait", 32'(upOut), 32'(stat));
      readyIn = (k == waits) ? 1'b1 : 1'b0;
    end
    @(negedge clk);  // T4
    chk("R4 strobes off T4", 32'({rdN, wrN}), 32'h3);
    chk("R9 denN off T4", 32'(denN), 1);
    chk("R7 adOe T4", 32'(adOe), 32'(wr));
    chk("R8 dtR T4", 32'(dtR), 32'(wr));
    chk("R10 bheN T4", 32'(bheN), 32'(expBhe));
    chk("R11 no done in T4", 32'(doneValid), 0);
    adIn = 16'hDEAD;
    @(negedge clk);  // idle, done
    chk("R11 done pulse", 32'(doneValid), 1);
    if (!wr) chk("R6 read data", 32'(rdData), 32'(expRd));
    chk("R10 bheN idle", 32'(bheN), 1);
    chk("R8 idle dir", 32'({dtR, mIo}), 0);
    chk("R2 ale idle", 32'(aleOut), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R4 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chkIdle("R12 during reset");
    chk("R11 no done in reset", 32'(doneValid), 0);
    rst = 1'b0;
    @(negedge clk);
    chkIdle("R12 after reset");

    // directed address cases, R1
    xfer(16'h1230, 16'h0045, 16'h0000, 16'hA55A, 1'b0, 1'b0, 1'b0, 0);
    xfer(16'hFFFF, 16'hFFFF, 16'h0000, 16'h1234, 1'b0, 1'b0, 1'b0, 1);
    xfer(16'hFFFF, 16'h0010, 16'hBEEF, 16'h0000, 1'b1, 1'b0, 1'b1, 0);

    // sweep: io x write x size/alignment x waits
    for (int io = 0; io < 2; io++)
      for (int wr = 0; wr < 2; wr++)
        for (int sz = 0; sz < 3; sz++)
          for (int w = 0; w < 4; w++) begin
            int idx;
            logic [15:0] s, o, wd, rv;
            idx = ((io * 2 + wr) * 3 + sz) * 4 + w;
            s  = 16'h1230 + 16'(idx) * 16'h0111;
            o  = (16'h0044 + 16'(idx) * 16'h1357) & 16'hFFFE;
            if (sz == 2) o = o | 16'h0001;
            wd = 16'h8C31 ^ (16'(idx) * 16'h0707);
            rv = 16'h3C5A + 16'(idx) * 16'h1111;
            xfer(s, o, wd, rv, wr[0], io[0], (sz == 0), w);
          end

    // R12: abort a read during wait states
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqIo = 1'b1; reqWord = 1'b1;
    reqSeg = 16'h4000; reqOff = 16'h0002; readyIn = 1'b0;
    @(negedge clk);  // T1
    reqValid = 1'b0;
    repeat (3) @(negedge clk);  // T2, T3, wait
    chk("R5 wait before abort", 32'(rdN), 0);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chkIdle("R12 abort");
    rst = 1'b0;
    readyIn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R12 no done after abort", 32'(doneValid), 0);
      chk("R12 idle after abort", 32'({rdN, wrN, aleOut}), 32'h6);
    end
    xfer(16'h0001, 16'h0003, 16'h0000, 16'h7788, 1'b0, 1'b0, 1'b0, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule